// File: doc/BRIEF.md
# SPI Port Role Controller

This block chooses the role of one SPI port: off, bus master, or slave. Its inputs are three configuration bits held in registers (port enable, a bit that makes the port ignore its slave-select pin, and a master request), a one-cycle clear strobe for the fault flag, and the raw slave-select pin. From these it drives a pad-ownership select and per-pad output enables for the MISO, MOSI and serial-clock pads. It also raises a flag while the port is being selected through its pin.

The slave-select pin is asynchronous, so it first passes through a synchroniser. Suppose the port is a master that honours its pin, and another master pulls that pin low. The block then releases its MOSI and clock drivers at once and acts as a selected slave. On the next edge it clears its own master bit and sets a sticky mode-fault flag, which stays set until software clears it. When the ignore bit is set, the pin is cut off entirely, and the master bit alone picks the role.

Top module: `spi_mode_ctrl`

## Requirements
- R1: While reset is held and just after it is released, every status output is 0. This means the role is off (code 2'b00), no pad belongs to the port, no output enable is set and the fault flag is clear.
- R2: When the enable bit is 0, the role code is 2'b00, `pad_sel` and all three output enables are 0, and `ss_active` is 0. This holds whatever the other bits and the pin are.
- R3: With enable=1, ignore=0 and the synchronised pin low, the role code is 2'b10 (selected slave). `pad_sel` and `miso_oe` are 1, and `mosi_oe` and `sck_oe` are 0. This holds even in a cycle where the master bit is still 1.
- R4: With enable=1, ignore=0, master=0 and the synchronised pin high, the role code is 2'b11 (idle slave). `pad_sel` is 1 and all three output enables are 0, so MISO is high-impedance.
- R5: With enable=1, master=1 and either ignore=1 or the synchronised pin high, the role code is 2'b01 (master). `pad_sel`, `mosi_oe` and `sck_oe` are 1 and `miso_oe` is 0.
- R6: A change on `ss_n_in` reaches the outputs after exactly two rising clock edges, and not after one.
- R7: When enable=1, ignore=0, master=1 and the synchronised pin is low, the next edge clears the master bit and sets `mode_fault` on that same edge.
- R8: A configuration write that requests master=1 in a cycle where a demotion fires leaves the master bit at 0.
- R9: `mode_fault` stays set until a cycle with `fault_clr`=1. If a demotion sets it in that same cycle, it stays set.
- R10: With ignore=1, the pin changes neither the role nor `miso_oe`. No demotion happens, and a slave in this setting drives MISO (role code 2'b10).
- R11: `ss_active` is 1 exactly when enable=1, ignore=0 and the synchronised pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the three configuration bits |
| cfg_enable | input | 1 | Port enable value to write |
| cfg_ss_ignore | input | 1 | Ignore-slave-select value to write |
| cfg_master | input | 1 | Master request value to write |
| fault_clr | input | 1 | Clears the mode-fault flag (write-one-to-clear) |
| ss_n_in | input | 1 | Raw active-low slave-select pin |
| stat_enable | output | 1 | Current enable bit |
| stat_ss_ignore | output | 1 | Current ignore bit |
| stat_master | output | 1 | Current master bit |
| mode | output | 2 | Role: 00 off, 01 master, 10 selected slave, 11 idle slave |
| pad_sel | output | 1 | 1 when the SPI function owns its pads |
| miso_oe | output | 1 | MISO output enable |
| mosi_oe | output | 1 | MOSI output enable |
| sck_oe | output | 1 | Serial clock output enable |
| ss_active | output | 1 | Port currently selected through its pin |
| mode_fault | output | 1 | Sticky flag: master was demoted by the pin |

## Verification
A wrong configuration or fault bit appears on the status outputs one edge after the write or demotion that set it. Because the role decode is combinational, it also shows on the role code and pad enables in that same cycle. A synchroniser with the wrong depth shows as a role change one edge early or late after a pin transition. A bad priority between demotion, writes and fault clearing leaves the master bit or the fault flag wrong on the first edge after the conflict.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_MASTER   = 2'b01,
        MODE_SLV_SEL  = 2'b10,
        MODE_SLV_IDLE = 2'b11
    } spi_mode_e;

    typedef struct packed {
        logic enable;
        logic ss_ignore;
        logic master;
        logic fault;
    } ctrl_bits_t;

    typedef struct packed {
        logic pad_sel;
        logic miso_oe;
        logic mosi_oe;
        logic sck_oe;
    } pad_ctrl_t;

    localparam ctrl_bits_t CTRL_RESET = '{enable: 1'b0, ss_ignore: 1'b0,
                                          master: 1'b0, fault: 1'b0};

endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] stages_d;
    logic [LAST:0] stages_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                stages_d = async_in;
            end
        end else begin : g_chain
            always_comb begin
                stages_d = {stages_q[LAST-1:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stages_q <= {STAGES{RESET_VAL}};
        end else begin
            stages_q <= stages_d;
        end
    end

    assign sync_out = stages_q[LAST];

endmodule

// File: rtl/spi_mode_regs.sv
module spi_mode_regs
    import spi_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_enable,
    input  logic       cfg_ss_ignore,
    input  logic       cfg_master,
    input  logic       fault_clr,
    input  logic       ss_low,
    output ctrl_bits_t ctrl_q,
    output logic       demote
);
    ctrl_bits_t ctrl_d;

    // Demotion is judged on the registered bits, not on a pending write.
    always_comb begin
        ctrl_d = ctrl_q;
        demote = ctrl_q.enable && !ctrl_q.ss_ignore && ctrl_q.master && ss_low;
        if (cfg_we) begin
            ctrl_d.enable    = cfg_enable;
            ctrl_d.ss_ignore = cfg_ss_ignore;
            ctrl_d.master    = cfg_master;
        end
        if (fault_clr) begin
            ctrl_d.fault = 1'b0;
        end
        if (demote) begin
            ctrl_d.master = 1'b0;
            ctrl_d.fault  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    p_demote_clears_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.enable && !ctrl_q.ss_ignore && ctrl_q.master && ss_low) |=> !ctrl_q.master);

    p_demote_sets_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.enable && !ctrl_q.ss_ignore && ctrl_q.master && ss_low) |=> ctrl_q.fault);

    p_demote_beats_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (demote && cfg_we && cfg_master) |=> !ctrl_q.master);

    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.fault && !fault_clr) |=> ctrl_q.fault);

    p_ignore_holds_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ss_ignore && !cfg_we) |=> $stable(ctrl_q.master));

endmodule

// File: rtl/spi_mode_decode.sv
module spi_mode_decode
    import spi_mode_pkg::*;
(
    input  ctrl_bits_t ctrl,
    input  logic       ss_low,
    output spi_mode_e  mode,
    output pad_ctrl_t  pads,
    output logic       ss_active
);
    logic pin_selects;

    always_comb begin
        pin_selects = ctrl.enable && !ctrl.ss_ignore && ss_low;
        ss_active   = pin_selects;

        if (!ctrl.enable) begin
            mode = MODE_OFF;
        end else if (ctrl.ss_ignore) begin
            mode = ctrl.master ? MODE_MASTER : MODE_SLV_SEL;
        end else if (pin_selects) begin
            mode = MODE_SLV_SEL;
        end else begin
            mode = ctrl.master ? MODE_MASTER : MODE_SLV_IDLE;
        end

        unique case (mode)
            MODE_OFF:      pads = '{pad_sel: 1'b0, miso_oe: 1'b0, mosi_oe: 1'b0, sck_oe: 1'b0};
            MODE_MASTER:   pads = '{pad_sel: 1'b1, miso_oe: 1'b0, mosi_oe: 1'b1, sck_oe: 1'b1};
            MODE_SLV_SEL:  pads = '{pad_sel: 1'b1, miso_oe: 1'b1, mosi_oe: 1'b0, sck_oe: 1'b0};
            default:       pads = '{pad_sel: 1'b1, miso_oe: 1'b0, mosi_oe: 1'b0, sck_oe: 1'b0};
        endcase
    end

endmodule

// File: rtl/spi_mode_ctrl.sv
module spi_mode_ctrl
    import spi_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_enable,
    input  logic       cfg_ss_ignore,
    input  logic       cfg_master,
    input  logic       fault_clr,
    input  logic       ss_n_in,
    output logic       stat_enable,
    output logic       stat_ss_ignore,
    output logic       stat_master,
    output logic [1:0] mode,
    output logic       pad_sel,
    output logic       miso_oe,
    output logic       mosi_oe,
    output logic       sck_oe,
    output logic       ss_active,
    output logic       mode_fault
);
    logic       ss_n_sync;
    logic       ss_low;
    logic       demote;
    ctrl_bits_t ctrl_q;
    spi_mode_e  mode_w;
    pad_ctrl_t  pads_w;

    spi_ss_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_ss_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ss_n_in),
        .sync_out (ss_n_sync)
    );

    assign ss_low = !ss_n_sync;

    spi_mode_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_enable    (cfg_enable),
        .cfg_ss_ignore (cfg_ss_ignore),
        .cfg_master    (cfg_master),
        .fault_clr     (fault_clr),
        .ss_low        (ss_low),
        .ctrl_q        (ctrl_q),
        .demote        (demote)
    );

    spi_mode_decode u_decode (
        .ctrl      (ctrl_q),
        .ss_low    (ss_low),
        .mode      (mode_w),
        .pads      (pads_w),
        .ss_active (ss_active)
    );

    assign stat_enable    = ctrl_q.enable;
    assign stat_ss_ignore = ctrl_q.ss_ignore;
    assign stat_master    = ctrl_q.master;
    assign mode_fault     = ctrl_q.fault;
    assign mode           = mode_w;
    assign pad_sel        = pads_w.pad_sel;
    assign miso_oe        = pads_w.miso_oe;
    assign mosi_oe        = pads_w.mosi_oe;
    assign sck_oe         = pads_w.sck_oe;

    p_pads_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_enable |-> (!pad_sel && !miso_oe && !mosi_oe && !sck_oe && !ss_active));

    p_pin_select_drops_drivers_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |-> (miso_oe && !mosi_oe && !sck_oe));

    p_idle_slave_miso_tristate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_enable && !stat_ss_ignore && !stat_master && !ss_active) |-> !miso_oe);

    p_single_driver_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !(mosi_oe || sck_oe));

    p_demote_observed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (demote && !fault_clr) |=> (mode_fault && !stat_master));

endmodule

// File: tb/spi_mode_ctrl_tb.sv
module spi_mode_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_ss_ignore = 1'b0;
    logic       cfg_master = 1'b0;
    logic       fault_clr = 1'b0;
    logic       ss_n_in = 1'b1;
    logic       stat_enable, stat_ss_ignore, stat_master;
    logic [1:0] mode;
    logic       pad_sel, miso_oe, mosi_oe, sck_oe, ss_active, mode_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    spi_mode_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_enable     (cfg_enable),
        .cfg_ss_ignore  (cfg_ss_ignore),
        .cfg_master     (cfg_master),
        .fault_clr      (fault_clr),
        .ss_n_in        (ss_n_in),
        .stat_enable    (stat_enable),
        .stat_ss_ignore (stat_ss_ignore),
        .stat_master    (stat_master),
        .mode           (mode),
        .pad_sel        (pad_sel),
        .miso_oe        (miso_oe),
        .mosi_oe        (mosi_oe),
        .sck_oe         (sck_oe),
        .ss_active      (ss_active),
        .mode_fault     (mode_fault)
    );

    // {en, ign, mst, fault, mode[1:0], pad_sel, miso, mosi, sck, ss_active}
    function automatic logic [10:0] model(logic en, logic ign, logic mst, logic flt, logic ssl);
        logic [1:0] m;
        logic [3:0] p;
        logic       sa;
        sa = en && !ign && ssl;
        if (!en)      m = 2'b00;
        else if (ign) m = mst ? 2'b01 : 2'b10;
        else if (ssl) m = 2'b10;
        else          m = mst ? 2'b01 : 2'b11;
        case (m)
            2'b00:   p = 4'b0000;
            2'b01:   p = 4'b1011;
            2'b10:   p = 4'b1100;
            default: p = 4'b1000;
        endcase
        return {en, ign, mst, flt, m, p, sa};
    endfunction

    function automatic logic [10:0] observed();
        return {stat_enable, stat_ss_ignore, stat_master, mode_fault, mode,
                pad_sel, miso_oe, mosi_oe, sck_oe, ss_active};
    endfunction

    task automatic check(string tag, logic [10:0] exp);
        logic [10:0] act;
        act = observed();
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_cfg(logic en, logic ign, logic mst);
        cfg_we = 1'b1; cfg_enable = en; cfg_ss_ignore = ign; cfg_master = mst;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic set_ss(logic v);
        ss_n_in = v;
        repeat (3) tick();
    endtask

    task automatic clear_all();
        write_cfg(1'b0, 1'b0, 1'b0);
        fault_clr = 1'b1;
        tick();
        fault_clr = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) tick();
        check("R1 in reset", 11'b0);
        rst_n = 1'b1;
        tick();
        check("R1 after reset", 11'b0);

        // Sweep every configuration against both pin levels.
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 8; c++) begin
                logic en, ign, mst, ssl;
                string tag;
                en = c[2]; ign = c[1]; mst = c[0]; ssl = (s == 0);
                if (!en)            tag = "R2";
                else if (ign)       tag = "R10";
                else if (ssl && mst) tag = "R7";
                else if (ssl)       tag = "R3";
                else if (mst)       tag = "R5";
                else                tag = "R4";
                clear_all();
                set_ss(!ssl);
                write_cfg(en, ign, mst);
                check({tag, " sweep write"}, model(en, ign, mst, 1'b0, ssl));
                repeat (2) tick();
                if (en && !ign && mst && ssl)
                    check({tag, " sweep settled"}, model(en, ign, 1'b0, 1'b1, ssl));
                else
                    check({tag, " sweep settled"}, model(en, ign, mst, 1'b0, ssl));
            end
        end

        // R6: two-edge latency, then R7 demotion on the following edge.
        clear_all();
        set_ss(1'b1);
        write_cfg(1'b1, 1'b0, 1'b1);
        check("R5 master idle", model(1, 0, 1, 0, 0));
        ss_n_in = 1'b0;
        tick();
        check("R6 one edge", model(1, 0, 1, 0, 0));
        tick();
        check("R6 two edges R3", model(1, 0, 1, 0, 1));
        tick();
        check("R7 demoted", model(1, 0, 0, 1, 1));
        ss_n_in = 1'b1;
        repeat (2) tick();
        check("R9 sticky R11 R4", model(1, 0, 0, 1, 0));
        fault_clr = 1'b1;
        tick();
        fault_clr = 1'b0;
        check("R9 cleared", model(1, 0, 0, 0, 0));

        // R8: master write and fault clear in the demotion cycle.
        write_cfg(1'b1, 1'b0, 1'b1);
        ss_n_in = 1'b0;
        repeat (2) tick();
        cfg_we = 1'b1; cfg_enable = 1'b1; cfg_ss_ignore = 1'b0; cfg_master = 1'b1;
        fault_clr = 1'b1;
        tick();
        cfg_we = 1'b0; fault_clr = 1'b0;
        check("R8 demotion wins, R9 set beats clear", model(1, 0, 0, 1, 1));

        // R10: ignore bit isolates the pin.
        clear_all();
        set_ss(1'b1);
        write_cfg(1'b1, 1'b1, 1'b1);
        ss_n_in = 1'b0;
        repeat (4) tick();
        check("R10 master holds", model(1, 1, 1, 0, 1));
        write_cfg(1'b1, 1'b1, 1'b0);
        check("R10 slave pin low", model(1, 1, 0, 0, 1));
        set_ss(1'b1);
        check("R10 slave pin high", model(1, 1, 0, 0, 0));

        done = 1'b1;
        report();
    end

endmodule